// File: doc/BRIEF.md
# Per-Thread Pause Stall Counter

This block holds one or more hardware threads in a stalled state for a requested number of clock cycles. A single write port names a thread and a cycle amount. The amount is reduced to a coarse count of 8-cycle periods, and the thread's stall output stays high until that count drains to zero. Amounts below one period still give a single stall cycle.

A per-thread disrupting trap input cancels a stall at once. A later write to a thread that is already stalled overrides the count it has left. Each thread's remaining period count is also exposed, so a scheduler or a debug view can see how far a stall has progressed. The scheduler that consumes the stall lines, the trap sources and the logic that picks the amount are all outside the block.

Top module: `pause_stall_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every stall bit is 0 and every remaining-count field is 0.
- R2: A write of amount A >= 8 to thread t (wr_en high, wr_thread = t) raises stall[t] in the next cycle and holds it for exactly 8 * floor(A/8) cycles.
- R3: Thread t's remaining-count field sits at bits [t*CW +: CW] of remain, where CW = AMT_W - 3. It reads floor(A/8) in the cycle after the write and then drops by one every 8 cycles. The first drop comes 8 cycles after the load.
- R4: A write of an amount below 8, including 0, stalls the thread for exactly one cycle, and its remaining count stays 0.
- R5: When trap[t] is high at a clock edge, stall[t] and thread t's remaining count are both 0 from the next cycle on.
- R6: When a trap and a write reach the same thread in the same cycle, the trap wins and no stall starts.
- R7: A write to a thread that is already stalled replaces the remaining count and restarts the 8-cycle phase. The new stall lasts exactly as long as it would from an idle thread.
- R8: A write or trap aimed at one thread leaves every other thread's stall bit and remaining count unchanged. An idle thread that gets no write stays idle, and nothing is loaded while wr_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a pause amount |
| wr_thread | input | TID_W | Thread index targeted by the write |
| wr_amount | input | AMT_W | Requested stall length in cycles |
| trap | input | NUM_THREADS | Per-thread disrupting trap, aborts the stall |
| stall | output | NUM_THREADS | Per-thread stall indication |
| remain | output | NUM_THREADS*CW | Per-thread remaining 8-cycle periods |

## Verification
The in-RTL assertions check several rules on every cycle. A load captures the amount shifted down by three. The count moves only on a period tick, and then by exactly one. A trap leaves the thread idle with a zero count. A one-cycle minimum stall always ends after a single cycle, and an idle thread with no write stays idle. Other properties need whole scenarios and are shown by the bench: the exact total stall length for each amount, the placement of the first decrement, the restarted phase after an overriding write, and the isolation of one thread's activity from another's.

// File: rtl/pause_pkg.sv
package pause_pkg;

    // log2 of the counter tick period (8 cycles)
    localparam int unsigned GRAN_SHIFT = 3;

    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_ABORT = 2'd1,
        UPD_LOAD  = 2'd2,
        UPD_STEP  = 2'd3
    } upd_kind_e;

    // Priority: trap abort, then load, then periodic step.
    function automatic upd_kind_e classify_update(input logic abort_i,
                                                  input logic load_i,
                                                  input logic step_i);
        if (abort_i) return UPD_ABORT;
        if (load_i)  return UPD_LOAD;
        if (step_i)  return UPD_STEP;
        return UPD_IDLE;
    endfunction

endpackage

// File: rtl/pause_wr_decode.sv
module pause_wr_decode #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [TID_W-1:0]       wr_thread,
    output logic [NUM_THREADS-1:0] load
);

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_dec
        assign load[i] = wr_en && (wr_thread == TID_W'(i));
    end

    assert_single_load_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load));

    assert_no_load_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (load == '0));

endmodule

// File: rtl/pause_tick_gen.sv
module pause_tick_gen #(
    parameter int unsigned SHIFT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);

    logic [SHIFT-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == {SHIFT{1'b1}});

    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(phase_q));

endmodule

// File: rtl/pause_thread_ctr.sv
module pause_thread_ctr
    import pause_pkg::*;
#(
    parameter int unsigned AMT_W = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [AMT_W-1:0]             amount,
    input  logic                         trap,
    output logic                         stall,
    output logic [AMT_W-GRAN_SHIFT-1:0]  remain
);

    localparam int unsigned CW = AMT_W - GRAN_SHIFT;

    typedef struct packed {
        logic [CW-1:0] periods;
        logic          min_hold;
    } tstate_t;

    tstate_t   st_q, st_d;
    logic      tick;
    logic [CW-1:0] ticks_req;
    upd_kind_e kind;

    assign ticks_req = amount[AMT_W-1:GRAN_SHIFT];

    pause_tick_gen #(.SHIFT(GRAN_SHIFT)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (load || trap),
        .run   (st_q.periods != '0),
        .tick  (tick)
    );

    always_comb begin
        kind = classify_update(trap, load, tick);
        st_d = st_q;
        st_d.min_hold = 1'b0;
        case (kind)
            UPD_ABORT: st_d = '0;
            UPD_LOAD: begin
                st_d.periods  = ticks_req;
                st_d.min_hold = (ticks_req == '0);
            end
            UPD_STEP: st_d.periods = st_q.periods - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall  = (st_q.periods != '0) || st_q.min_hold;
    assign remain = st_q.periods;

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !trap) |=> (remain == $past(ticks_req)));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && !trap) |=> (remain == $past(remain) - 1'b1));

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !trap) |=> $stable(remain));

    assert_min_start_R4: assert property (@(posedge clk) disable iff (rst)
        (load && !trap && ticks_req == '0) |=> (stall && remain == '0));

    assert_min_end_R4: assert property (@(posedge clk) disable iff (rst)
        (stall && remain == '0 && !load && !trap) |=> !stall);

    assert_trap_abort_R5: assert property (@(posedge clk) disable iff (rst)
        trap |=> (!stall && remain == '0));

    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load) |=> !stall);

endmodule

// File: rtl/pause_stall_ctrl.sv
module pause_stall_ctrl
    import pause_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned AMT_W       = 12,
    localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int unsigned CW         = AMT_W - GRAN_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [TID_W-1:0]          wr_thread,
    input  logic [AMT_W-1:0]          wr_amount,
    input  logic [NUM_THREADS-1:0]    trap,
    output logic [NUM_THREADS-1:0]    stall,
    output logic [NUM_THREADS*CW-1:0] remain
);

    logic [NUM_THREADS-1:0] load;

    pause_wr_decode #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_thread (wr_thread),
        .load      (load)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        pause_thread_ctr #(.AMT_W(AMT_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .load   (load[t]),
            .amount (wr_amount),
            .trap   (trap[t]),
            .stall  (stall[t]),
            .remain (remain[t*CW +: CW])
        );
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (stall == '0 && remain == '0));

endmodule

// File: tb/pause_stall_ctrl_test.sv
module pause_stall_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 4;
    localparam int AW   = 12;
    localparam int CW   = AW - 3;
    localparam int NVEC = 8;

    localparam int VEC_THR [NVEC] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int VEC_AMT [NVEC] = '{0, 7, 8, 15, 16, 23, 100, 255};
    localparam int VEC_CYC [NVEC] = '{1, 1, 8, 8, 16, 16, 96, 248};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_thread = '0;
    logic [AW-1:0] wr_amount = '0;
    logic [NT-1:0] trap = '0;
    logic [NT-1:0] stall;
    logic [NT*CW-1:0] remain;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_stall_ctrl #(.NUM_THREADS(NT), .AMT_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_thread(wr_thread),
        .wr_amount(wr_amount), .trap(trap), .stall(stall), .remain(remain)
    );

    function automatic int rem_of(input int t);
        return int'(remain[t*CW +: CW]);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, return at the negedge after the load edge
    task automatic do_write(input int t, input int a, input bit with_trap);
        @(negedge clk);
        wr_en = 1'b1; wr_thread = 2'(t); wr_amount = AW'(a);
        if (with_trap) trap[t] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; trap = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count stall cycles of thread t from now, including the current one
    task automatic count_stall(input int t, output int cyc);
        cyc = 0;
        while (stall[t] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        wait_cyc(3);
        check(stall == '0, "R1 stall in reset", int'(stall), 0);
        rst = 1'b0;
        @(negedge clk);
        check(stall == '0 && remain == '0, "R1 after reset", int'(stall), 0);

        // table walk: R2 / R4 / R3 start value
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC_THR[v], VEC_AMT[v], 1'b0);
            check(rem_of(VEC_THR[v]) == VEC_AMT[v] / 8, "R3 loaded count",
                  rem_of(VEC_THR[v]), VEC_AMT[v] / 8);
            count_stall(VEC_THR[v], cyc);
            check(cyc == VEC_CYC[v], (VEC_AMT[v] < 8) ? "R4 min stall" : "R2 stall length",
                  cyc, VEC_CYC[v]);
            wait_cyc(2);
        end

        // R3: first drop exactly 8 cycles after load
        do_write(1, 40, 1'b0);
        wait_cyc(7);
        check(rem_of(1) == 5, "R3 before first drop", rem_of(1), 5);
        wait_cyc(1);
        check(rem_of(1) == 4, "R3 first drop", rem_of(1), 4);
        wait_cyc(8);
        check(rem_of(1) == 3, "R3 second drop", rem_of(1), 3);
        count_stall(1, cyc);
        check(cyc == 24, "R3 drain", cyc, 24);

        // R5: trap mid-stall
        do_write(2, 64, 1'b0);
        wait_cyc(10);
        trap[2] = 1'b1;
        @(negedge clk);
        trap = '0;
        check(!stall[2] && rem_of(2) == 0, "R5 trap abort", int'(stall[2]), 0);
        wait_cyc(3);
        check(!stall[2], "R5 stays idle", int'(stall[2]), 0);

        // R6: trap and write same cycle
        do_write(0, 64, 1'b1);
        check(!stall[0] && rem_of(0) == 0, "R6 trap wins", rem_of(0), 0);

        // R7: overriding write restarts phase
        do_write(3, 80, 1'b0);
        wait_cyc(20);
        check(rem_of(3) == 8, "R7 partial drain", rem_of(3), 8);
        do_write(3, 16, 1'b0);
        check(rem_of(3) == 2, "R7 replaced count", rem_of(3), 2);
        count_stall(3, cyc);
        check(cyc == 16, "R7 replaced length", cyc, 16);

        // R7 + R4: zero write onto a running stall
        do_write(2, 200, 1'b0);
        wait_cyc(5);
        do_write(2, 0, 1'b0);
        count_stall(2, cyc);
        check(cyc == 1, "R7 zero override", cyc, 1);

        // R8: isolation between threads
        do_write(0, 80, 1'b0);
        do_write(1, 8, 1'b0);
        check(stall[0] && rem_of(0) == 10, "R8 other write", rem_of(0), 10);
        trap[1] = 1'b1;
        @(negedge clk);
        trap = '0;
        check(stall[0] && rem_of(0) == 10 && !stall[1], "R8 other trap", rem_of(0), 10);
        check(stall[3:2] == 2'b00, "R8 untouched threads", int'(stall[3:2]), 0);
        trap[0] = 1'b1;
        @(negedge clk);
        trap = '0;

        // R8: amount presented with wr_en low loads nothing
        wr_thread = 2'd3; wr_amount = AW'(120);
        wait_cyc(2);
        check(stall == '0 && remain == '0, "R8 no strobe", int'(stall), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule